// File: doc/BRIEF.md
# Secure-Banked System Region Router

This block decodes accesses to a processor's private system region and routes each one to a system-register target, one of two banked tick-timer targets, or an optional RAS target. Any access that no target claims is answered locally by a default responder. The windows overlap and are resolved by a fixed priority: the tick-timer window sits inside the system-register page and wins there. A further option adds a non-secure alias page. A secure access through the alias reaches the same target as through the main page, but with its secure attribute cleared. A non-secure access through the alias is refused.

Requests arrive on a valid/ready channel together with the address, size, write flag, write data and the secure and user attributes. Decoding is combinational, so a one-hot target select and the rewritten attributes appear in the same cycle as the accepted request. The selected target's read data and error are captured into a single response register, which is offered on a valid/ready response channel.

Back-pressure has one rule. `req_ready` is high whenever the response register is empty, or is being drained in the same cycle. While a response waits with `rsp_ready` low, no new request is taken and the held response does not change.

Top module: `sysrr_region_router`

## Requirements
- R1: After reset `rsp_valid` is 0, and `tgt_sel` is all zero while no request is accepted.
- R2: An accepted access that no enabled window claims asserts no target select. Its response has read data 0 and error equal to `req_user` (privileged: read as zero, write ignored; unprivileged: bus error).
- R3: An access whose address has bits [31:12] = 0xE000E and that lies outside the tick window selects the system-register target (`tgt_sel` bit 0). It carries offset `addr[11:0]` and the unchanged secure attribute.
- R4: The tick window covers page offsets 0x010 to 0x0EF and takes priority over the system-register target. The offset presented is the page offset minus 0x010.
- R5: A tick access is routed by its effective secure attribute: secure selects `tgt_sel` bit 2, non-secure selects `tgt_sel` bit 1.
- R6: With V8_EN=1, a secure access to page 0xE002E is routed exactly as the same offset in page 0xE000E would be, but with `tgt_secure` 0. A tick access through the alias therefore reaches the non-secure timer (bit 1).
- R7: A non-secure access to the alias page selects no target and is answered as in R2.
- R8: With RAS_EN=1, page 0xE0005 selects the RAS target (`tgt_sel` bit 3) with offset `addr[11:0]`.
- R9: With V8_EN=0 or RAS_EN=0, the corresponding pages fall through to the default responder.
- R10: One clock after an accepted request, `rsp_valid` is 1. `rsp_rdata` holds the selected target's read data for a read, or 0 for a write. `rsp_err` holds that target's error bit.
- R11: `req_ready` equals `!rsp_valid || rsp_ready`. While `rsp_valid` is high and `rsp_ready` is low, the response stays unchanged and no target is selected.
- R12: All four size codes are accepted (code n means 2^n bytes, 1 to 8). Size, write flag, write data and user attribute pass to the targets unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_addr | input | 32 | Absolute byte address |
| req_size | input | 2 | Log2 of access size in bytes |
| req_write | input | 1 | 1 = write |
| req_wdata | input | DW | Write data |
| req_secure | input | 1 | Secure attribute of the caller |
| req_user | input | 1 | Unprivileged attribute of the caller |
| tgt_sel | output | TGT_N | One-hot select: 0 system registers, 1 non-secure timer, 2 secure timer, 3 RAS |
| tgt_offset | output | 12 | Offset within the selected window |
| tgt_size | output | 2 | Size passed to the target |
| tgt_write | output | 1 | Write flag passed to the target |
| tgt_wdata | output | DW | Write data passed to the target |
| tgt_secure | output | 1 | Possibly rewritten secure attribute |
| tgt_user | output | 1 | User attribute passed to the target |
| tgt_rdata | input | TGT_N*DW | Read data of each target, target i at bits [i*DW +: DW] |
| tgt_err | input | TGT_N | Error bit of each target |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumed when high together with rsp_valid |
| rsp_rdata | output | DW | Response read data |
| rsp_err | output | 1 | Response bus error |

## Verification
The main sweep steps through every page from 0xE0000 to 0xE002F. It uses offsets on each side of the tick-window edges and at the page ends, with all four secure/user combinations, reads and writes, and rotating sizes. This separates the priority between the tick and system-register windows, the bank choice by the secure attribute, the attribute rewrite in the alias, and the refusal of non-secure alias callers. A second instance built with both options off receives the same stream, so the fall-through of the alias and RAS pages shows up against the first instance. A dedicated back-pressure sequence holds `rsp_ready` low, to tell a held response apart from an overwritten one.

// File: rtl/sysrr_pkg.sv
package sysrr_pkg;
  localparam int TGT_N     = 4;
  localparam int TGT_W     = $clog2(TGT_N);
  localparam int T_SYS     = 0;
  localparam int T_TICK_NS = 1;
  localparam int T_TICK_S  = 2;
  localparam int T_RAS     = 3;

  typedef struct packed {
    logic             hit;     // 0: default responder answers
    logic [TGT_W-1:0] idx;
    logic             secure;
    logic [11:0]      offset;
  } route_t;
endpackage

// File: rtl/sysrr_decode.sv
module sysrr_decode
  import sysrr_pkg::*;
#(
  parameter bit          V8_EN      = 1'b1,
  parameter bit          RAS_EN     = 1'b1,
  parameter logic [19:0] SCS_PAGE   = 20'hE000E,
  parameter logic [19:0] ALIAS_PAGE = 20'hE002E,
  parameter logic [19:0] RAS_PAGE   = 20'hE0005,
  parameter logic [11:0] TICK_LO    = 12'h010,
  parameter logic [11:0] TICK_SPAN  = 12'h0E0
) (
  input  logic [31:0] addr,
  input  logic        secure,
  output route_t      rt
);
  localparam logic [11:0] TICK_HI = TICK_LO + TICK_SPAN;

  logic [11:0] off;
  logic        main_hit, alias_hit, ras_hit, tick_hit, eff_sec;

  assign off      = addr[11:0];
  assign main_hit = (addr[31:12] == SCS_PAGE);

  generate
    if (V8_EN) begin : g_alias
      assign alias_hit = (addr[31:12] == ALIAS_PAGE);
    end else begin : g_no_alias
      assign alias_hit = 1'b0;
    end
    if (RAS_EN) begin : g_ras
      assign ras_hit = (addr[31:12] == RAS_PAGE);
    end else begin : g_no_ras
      assign ras_hit = 1'b0;
    end
  endgenerate

  assign tick_hit = (main_hit || alias_hit) && (off >= TICK_LO) && (off < TICK_HI);
  assign eff_sec  = secure && !alias_hit;

  always_comb begin
    rt        = '0;
    rt.secure = secure;
    rt.offset = off;
    if (main_hit || (alias_hit && secure)) begin
      rt.hit    = 1'b1;
      rt.secure = eff_sec;
      if (tick_hit) begin
        rt.idx    = eff_sec ? TGT_W'(T_TICK_S) : TGT_W'(T_TICK_NS);
        rt.offset = off - TICK_LO;
      end else begin
        rt.idx = TGT_W'(T_SYS);
      end
    end else if (ras_hit) begin
      rt.hit = 1'b1;
      rt.idx = TGT_W'(T_RAS);
    end
  end
endmodule

// File: rtl/sysrr_resp.sv
module sysrr_resp
  import sysrr_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              hit,
  input  logic [TGT_W-1:0]  idx,
  input  logic              write,
  input  logic              user,
  input  logic [TGT_N*DW-1:0] tgt_rdata,
  input  logic [TGT_N-1:0]  tgt_err,
  input  logic              rsp_ready,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_rdata,
  output logic              rsp_err
);
  logic [DW-1:0] rd_arr [TGT_N];

  generate
    for (genvar i = 0; i < TGT_N; i++) begin : g_unpack
      assign rd_arr[i] = tgt_rdata[i*DW +: DW];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else if (fire) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= (hit && !write) ? rd_arr[idx] : '0;
      rsp_err   <= hit ? tgt_err[idx] : user;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/sysrr_region_router.sv
module sysrr_region_router
  import sysrr_pkg::*;
#(
  parameter int DW     = 32,
  parameter bit V8_EN  = 1'b1,
  parameter bit RAS_EN = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [31:0]         req_addr,
  input  logic [1:0]          req_size,
  input  logic                req_write,
  input  logic [DW-1:0]       req_wdata,
  input  logic                req_secure,
  input  logic                req_user,
  output logic [TGT_N-1:0]    tgt_sel,
  output logic [11:0]         tgt_offset,
  output logic [1:0]          tgt_size,
  output logic                tgt_write,
  output logic [DW-1:0]       tgt_wdata,
  output logic                tgt_secure,
  output logic                tgt_user,
  input  logic [TGT_N*DW-1:0] tgt_rdata,
  input  logic [TGT_N-1:0]    tgt_err,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [DW-1:0]       rsp_rdata,
  output logic                rsp_err
);
  route_t rt;
  logic   fire;

  sysrr_decode #(.V8_EN(V8_EN), .RAS_EN(RAS_EN)) u_dec (
    .addr   (req_addr),
    .secure (req_secure),
    .rt     (rt)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;

  generate
    for (genvar i = 0; i < TGT_N; i++) begin : g_sel
      assign tgt_sel[i] = fire && rt.hit && (rt.idx == TGT_W'(i));
    end
  endgenerate

  assign tgt_offset = rt.offset;
  assign tgt_secure = rt.secure;
  assign tgt_size   = req_size;
  assign tgt_write  = req_write;
  assign tgt_wdata  = req_wdata;
  assign tgt_user   = req_user;

  sysrr_resp #(.DW(DW)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (fire),
    .hit       (rt.hit),
    .idx       (rt.idx),
    .write     (req_write),
    .user      (req_user),
    .tgt_rdata (tgt_rdata),
    .tgt_err   (tgt_err),
    .rsp_ready (rsp_ready),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .rsp_err   (rsp_err)
  );
endmodule

// File: rtl/sysrr_checker.sv
module sysrr_checker
  import sysrr_pkg::*;
#(
  parameter int          DW         = 32,
  parameter bit          V8_EN      = 1'b1,
  parameter logic [19:0] ALIAS_PAGE = 20'hE002E
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [31:0]      req_addr,
  input logic             req_secure,
  input logic             rsp_ready,
  input logic             rsp_valid,
  input logic [DW-1:0]    rsp_rdata,
  input logic             rsp_err,
  input logic [TGT_N-1:0] tgt_sel,
  input logic             tgt_secure
);
  logic at_alias;
  assign at_alias = V8_EN && (req_addr[31:12] == ALIAS_PAGE);

  a_r1_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tgt_sel));

  a_r11_sel_needs_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_sel != '0) |-> (req_valid && req_ready));

  a_r10_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  a_r11_rsp_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)));

  a_r5_secure_bank: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_sel[T_TICK_S] |-> (req_secure && tgt_secure));

  a_r6_alias_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ((tgt_sel != '0) && at_alias) |-> !tgt_secure);

  a_r7_alias_refuses: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && at_alias && !req_secure) |-> (tgt_sel == '0));
endmodule

bind sysrr_region_router sysrr_checker #(.DW(DW), .V8_EN(V8_EN)) u_chk (.*);

// File: tb/sysrr_region_router_test.sv
module sysrr_region_router_test;
  localparam int DW = 32;
  localparam int TN = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          req_valid = 1'b0, req_write = 1'b0, req_secure = 1'b0, req_user = 1'b0;
  logic [31:0]   req_addr = '0;
  logic [1:0]    req_size = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_ready = 1'b1;

  logic [TN-1:0]    sel_a, sel_b, err_a, err_b;
  logic [11:0]      off_a, off_b;
  logic [1:0]       size_a, size_b;
  logic             wr_a, wr_b, sec_a, sec_b, usr_a, usr_b;
  logic [DW-1:0]    wd_a, wd_b, rd_a, rd_b;
  logic [TN*DW-1:0] trd_a, trd_b;
  logic             rdy_a, rdy_b, rv_a, rv_b, re_a, re_b;

  // Target stubs: data tags the target index and offset; error at offset 0xFFC.
  always_comb begin
    for (int i = 0; i < TN; i++) begin
      trd_a[i*DW +: DW] = {4'hA, 4'(i), 12'h000, off_a};
      trd_b[i*DW +: DW] = {4'hA, 4'(i), 12'h000, off_b};
      err_a[i] = (off_a == 12'hFFC);
      err_b[i] = (off_b == 12'hFFC);
    end
  end

  sysrr_region_router #(.DW(DW), .V8_EN(1'b1), .RAS_EN(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy_a),
    .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
    .req_wdata(req_wdata), .req_secure(req_secure), .req_user(req_user),
    .tgt_sel(sel_a), .tgt_offset(off_a), .tgt_size(size_a), .tgt_write(wr_a),
    .tgt_wdata(wd_a), .tgt_secure(sec_a), .tgt_user(usr_a),
    .tgt_rdata(trd_a), .tgt_err(err_a), .rsp_valid(rv_a), .rsp_ready(rsp_ready),
    .rsp_rdata(rd_a), .rsp_err(re_a));

  sysrr_region_router #(.DW(DW), .V8_EN(1'b0), .RAS_EN(1'b0)) uut_min (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy_b),
    .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
    .req_wdata(req_wdata), .req_secure(req_secure), .req_user(req_user),
    .tgt_sel(sel_b), .tgt_offset(off_b), .tgt_size(size_b), .tgt_write(wr_b),
    .tgt_wdata(wd_b), .tgt_secure(sec_b), .tgt_user(usr_b),
    .tgt_rdata(trd_b), .tgt_err(err_b), .rsp_valid(rv_b), .rsp_ready(rsp_ready),
    .rsp_rdata(rd_b), .rsp_err(re_b));

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h addr=%08h sec=%0b usr=%0b wr=%0b",
               tag, act, exp, req_addr, req_secure, req_user, req_write);
    end
  endtask

  // Expected routing computed from the requirements.
  task automatic model(input logic [31:0] a, input bit s, input bit v8, input bit ras,
                       output bit hit, output int idx, output bit osec, output logic [11:0] off);
    logic [19:0] pg;
    logic [11:0] o;
    bit al;
    pg = a[31:12]; o = a[11:0];
    al = v8 && (pg == 20'hE002E);
    hit = 1'b0; idx = 0; osec = s; off = o;
    if (pg == 20'hE000E || (al && s)) begin
      hit = 1'b1;
      osec = al ? 1'b0 : s;
      if (o >= 12'h010 && o < 12'h0F0) begin
        idx = osec ? 2 : 1;
        off = o - 12'h010;
      end
    end else if (ras && pg == 20'hE0005) begin
      hit = 1'b1; idx = 3;
    end
  endtask

  function automatic logic [31:0] exp_data(bit hit, bit wr, int idx, logic [11:0] off);
    return (hit && !wr) ? {4'hA, 4'(idx), 12'h000, off} : 32'h0;
  endfunction

  int offs [7] = '{12'h000, 12'h00C, 12'h010, 12'h0EC, 12'h0F0, 12'h100, 12'hFFC};

  initial begin
    bit ha, hb, sa, sb;
    int ia, ib;
    logic [11:0] oa, ob;
    string tag;
    int n = 0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(rv_a == 1'b0, "R1 rsp_valid", 64'(rv_a), 64'd0);
    check(sel_a == '0, "R1 tgt_sel", 64'(sel_a), 64'd0);

    // Sweep pages 0xE0000..0xE002F.
    for (int pg = 0; pg < 48; pg++) begin
      for (int k = 0; k < 7; k++) begin
        for (int at = 0; at < 4; at++) begin
          for (int w = 0; w < 2; w++) begin
            req_valid  = 1'b1;
            req_addr   = {20'hE0000 + 20'(pg), 12'(offs[k])};
            req_secure = at[0];
            req_user   = at[1];
            req_write  = w[0];
            req_size   = 2'(n);
            req_wdata  = 32'h5A00_0000 ^ 32'(n * 7);
            n++;
            #1;
            model(req_addr, req_secure, 1'b1, 1'b1, ha, ia, sa, oa);
            model(req_addr, req_secure, 1'b0, 1'b0, hb, ib, sb, ob);
            if (!ha) tag = (req_addr[31:12] == 20'hE002E) ? "R7" : "R2";
            else if (req_addr[31:12] == 20'hE002E) tag = "R6";
            else if (ia == 3) tag = "R8";
            else if (ia != 0) tag = "R4 R5";
            else tag = "R3";
            check(sel_a == (ha ? TN'(1 << ia) : TN'(0)), {tag, " sel"}, 64'(sel_a),
                  64'(ha ? (1 << ia) : 0));
            if (ha) begin
              check(off_a == oa && sec_a == sa, {tag, " offset/secure"},
                    64'({sec_a, off_a}), 64'({sa, oa}));
              check(size_a == req_size && wr_a == req_write && wd_a == req_wdata && usr_a == req_user,
                    "R12 passthrough", 64'({usr_a, wr_a, size_a, wd_a}),
                    64'({req_user, req_write, req_size, req_wdata}));
            end
            check(sel_b == (hb ? TN'(1 << ib) : TN'(0)), "R9 sel", 64'(sel_b),
                  64'(hb ? (1 << ib) : 0));
            @(posedge clk);
            @(negedge clk);
            check(rv_a && rd_a == exp_data(ha, req_write, ia, oa) &&
                  re_a == (ha ? (oa == 12'hFFC) : req_user),
                  ha ? "R10 rsp" : {tag, " rsp"}, 64'({rv_a, re_a, rd_a}),
                  64'({1'b1, (ha ? (oa == 12'hFFC) : req_user), exp_data(ha, req_write, ia, oa)}));
            check(rv_b && rd_b == exp_data(hb, req_write, ib, ob) &&
                  re_b == (hb ? (ob == 12'hFFC) : req_user),
                  "R9 rsp", 64'({rv_b, re_b, rd_b}),
                  64'({1'b1, (hb ? (ob == 12'hFFC) : req_user), exp_data(hb, req_write, ib, ob)}));
          end
        end
      end
    end

    // Back-pressure: R11.
    req_valid = 1'b0;
    @(negedge clk);
    rsp_ready  = 1'b0;
    req_valid  = 1'b1;
    req_addr   = 32'hE000_E100;
    req_write  = 1'b0;
    req_secure = 1'b1;
    req_user   = 1'b0;
    @(posedge clk);
    @(negedge clk);
    req_addr = 32'hE000_E020;
    #1;
    check(rdy_a == 1'b0, "R11 ready low", 64'(rdy_a), 64'd0);
    check(sel_a == '0, "R11 no select", 64'(sel_a), 64'd0);
    @(posedge clk);
    @(negedge clk);
    check(rv_a && rd_a == 32'hA000_0100, "R11 held", 64'(rd_a), 64'hA000_0100);
    rsp_ready = 1'b1;
    #1;
    check(rdy_a == 1'b1, "R11 ready high", 64'(rdy_a), 64'd1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(rv_a && rd_a == 32'hA200_0010, "R11 R10 next", 64'(rd_a), 64'hA200_0010);
    @(posedge clk);
    @(negedge clk);
    check(rv_a == 1'b0, "R11 drained", 64'(rv_a), 64'd0);
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule